// File: doc/BRIEF.md
# Parallel RGB Display Bus Formatter

This block sits between a display timing generator and the pins of a parallel RGB panel bus. Each pixel clock it takes one 24-bit pixel (8 bits per channel, red in the top byte) with its horizontal sync, vertical sync and data-enable strobes. It rearranges the three colour channels and packs the result onto 24 output lines in one of several layouts, from a full 8:8:8 bus down to reduced 5:6:5 and 6:6:6 buses with different pin spreads. Each of the three control strobes can be inverted, launched on the falling clock edge rather than the rising one, or gated off. The data-enable pin can instead carry a composite sync.

All of this is set by one control word, written and read through a small register port in the pixel clock domain. Every address other than the control word reads back a fixed identification constant. Clearing the enable bit holds the output quiet. Setting it again restarts the output pipeline from a clean state.

Top module: `pixfmt_top`

## Requirements
- R1: A read strobe (`reg_valid`=1, `reg_write`=0) returns, one clock later on `reg_rdata`, the control word when `reg_addr` is 0 and 0x00647069 at any other address. Bits 31:17 of the control word read as 0. A write (`reg_valid`=1, `reg_write`=1) to address 0 takes effect on the next clock edge. A write to any other address leaves the control word unchanged.
- R2: The order field (bits 15:14) selects the channels that become first, second and third: 0 gives R,G,B, 1 gives B,G,R, 2 gives G,R,B and 3 gives B,R,G. Here R is input bits 23:16, G is 15:8 and B is 7:0.
- R3: The 5:6:5 layouts use the top 5, 6 and 5 bits of the first, second and third channels. Format field (bits 13:11) value 1 places them at bits 15:11, 10:5 and 4:0. Value 2 places them at 20:16, 13:8 and 4:0. Value 3 places them at 21:17, 13:8 and 5:1. All other lines are 0.
- R4: The 6:6:6 layouts use the top 6 bits of each channel. Format 4 places them at 17:12, 11:6 and 5:0. Format 5 places them at 21:16, 13:8 and 5:0. Format 6 drives the three full channels at 23:16, 15:8 and 7:0. All other lines are 0.
- R5: Format values 0 and 7 drive all 24 data lines to 0.
- R6: Bits 9, 8 and 7 each reverse the polarity of the hsync, vsync and data-enable outputs respectively.
- R7: When bit 6, 5 or 4 is set, the hsync, vsync or data-enable output (respectively) changes on the falling clock edge that follows the rising edge that would otherwise have launched it. Pixel data always launches on the rising edge.
- R8: Bits 3, 2 and 1 gate off hsync, vsync and data-enable respectively. A gated signal sits at its inactive level, which is 0 when not inverted and 1 when inverted.
- R9: Reset clears all outputs and the control word. While the enable bit (bit 0) is 0, the data lines are 0, each strobe sits at its inactive level and the clock-invert output is 0. After the enable bit goes from 0 to 1, no data from before the enable appears: the first output edge shows 0 and the next shows the current input.
- R10: When bit 16 is 0, the data-enable pin carries composite sync instead of data-enable. Composite sync is 0 whenever hsync or vsync is active and 1 otherwise, before the data-enable invert and gate are applied.
- R11: Pixel data and every rising-launched strobe appear on the outputs one clock edge after the input is sampled.
- R12: `bus_pclk_inv` follows bit 10 of the control word, registered, while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after a read strobe |
| pix_rgb | input | 24 | Input pixel, R in 23:16, G in 15:8, B in 7:0 |
| pix_hsync | input | 1 | Horizontal sync, active high |
| pix_vsync | input | 1 | Vertical sync, active high |
| pix_de | input | 1 | Data enable, active high |
| bus_data | output | 24 | Packed output data lines |
| bus_hsync | output | 1 | Output horizontal sync |
| bus_vsync | output | 1 | Output vertical sync |
| bus_de | output | 1 | Output data enable or composite sync |
| bus_pclk_inv | output | 1 | Request to invert the pixel clock at the pins |

## Verification
The hardest case to reach from the ports is the half-cycle difference between rising-launched and falling-launched strobes. Both settle to the same value before the next rising edge, so a bench that samples only once per cycle cannot tell them apart. The stimulus changes the strobes and samples twice in the same cycle: once shortly after the rising edge and once after the falling edge. The expected value differs between the two samples only for the strobes whose launch bit is set. The restart on enable is also subtle. A non-zero pixel is held on the inputs while the block is disabled, and the bench checks that the edge carrying the enabling write still shows zero data.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

  localparam int CH_W     = 8;
  localparam int PIX_W    = 3 * CH_W;
  localparam int REG_W    = 32;
  localparam int NUM_SYNC = 3;
  localparam int W_FIVE   = CH_W - 3;
  localparam int W_SIX    = CH_W - 2;
  localparam logic [REG_W-1:0] ID_VALUE = 32'h0064_7069;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    FMT_OFF        = 3'd0,
    FMT_565_LOW    = 3'd1,
    FMT_565_SPREAD = 3'd2,
    FMT_565_SHIFT  = 3'd3,
    FMT_666_LOW    = 3'd4,
    FMT_666_SPREAD = 3'd5,
    FMT_888        = 3'd6,
    FMT_SPARE      = 3'd7
  } fmt_e;

  // Bit positions are software-visible: 16 mode, 15:14 order, 13:11 format,
  // 10 clock invert, 9:7 invert, 6:4 falling launch, 3:1 gate, 0 enable.
  typedef struct packed {
    logic       de_mode;
    logic [1:0] order;
    logic [2:0] fmt;
    logic       pclk_inv;
    logic [NUM_SYNC-1:0] inv;
    logic [NUM_SYNC-1:0] neg;
    logic [NUM_SYNC-1:0] dis;
    logic       enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pixfmt_ctrl_regs.sv
module pixfmt_ctrl_regs
  import pixfmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output ctrl_t             ctrl
);

  localparam int PAD_W = REG_W - CTRL_W;

  logic              sel_ctrl;
  logic              wr_en;
  logic              rd_en;
  ctrl_t             ctrl_d;
  ctrl_t             ctrl_q;
  logic [REG_W-1:0]  rdata_d;
  logic [REG_W-1:0]  rdata_q;
  logic              wdata_unused_bits;

  assign sel_ctrl          = (reg_addr == '0);
  assign wr_en             = reg_valid & reg_write & sel_ctrl;
  assign rd_en             = reg_valid & ~reg_write;
  assign wdata_unused_bits = ^reg_wdata[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d  = ctrl_q;
    rdata_d = rdata_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
    if (rd_en) begin
      rdata_d = sel_ctrl ? {{PAD_W{1'b0}}, ctrl_q} : ID_VALUE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign reg_rdata = rdata_q;

endmodule

// File: rtl/pixfmt_pack.sv
module pixfmt_pack
  import pixfmt_pkg::*;
(
  input  logic [1:0]       order,
  input  logic [2:0]       fmt,
  input  logic [PIX_W-1:0] rgb,
  output logic [PIX_W-1:0] packed_data
);

  logic [CH_W-1:0] ch_r, ch_g, ch_b;
  logic [CH_W-1:0] c0, c1, c2;

  assign ch_r = rgb[3*CH_W-1:2*CH_W];
  assign ch_g = rgb[2*CH_W-1:CH_W];
  assign ch_b = rgb[CH_W-1:0];

  always_comb begin
    unique case (order_e'(order))
      ORD_RGB: begin c0 = ch_r; c1 = ch_g; c2 = ch_b; end
      ORD_BGR: begin c0 = ch_b; c1 = ch_g; c2 = ch_r; end
      ORD_GRB: begin c0 = ch_g; c1 = ch_r; c2 = ch_b; end
      ORD_BRG: begin c0 = ch_b; c1 = ch_r; c2 = ch_g; end
      default: begin c0 = ch_r; c1 = ch_g; c2 = ch_b; end
    endcase
  end

  always_comb begin
    packed_data = '0;
    unique case (fmt_e'(fmt))
      FMT_565_LOW:
        packed_data = {8'b0, c0[CH_W-1 -: W_FIVE], c1[CH_W-1 -: W_SIX],
                       c2[CH_W-1 -: W_FIVE]};
      FMT_565_SPREAD:
        packed_data = {3'b0, c0[CH_W-1 -: W_FIVE], 2'b0, c1[CH_W-1 -: W_SIX],
                       3'b0, c2[CH_W-1 -: W_FIVE]};
      FMT_565_SHIFT:
        packed_data = {2'b0, c0[CH_W-1 -: W_FIVE], 3'b0, c1[CH_W-1 -: W_SIX],
                       2'b0, c2[CH_W-1 -: W_FIVE], 1'b0};
      FMT_666_LOW:
        packed_data = {6'b0, c0[CH_W-1 -: W_SIX], c1[CH_W-1 -: W_SIX],
                       c2[CH_W-1 -: W_SIX]};
      FMT_666_SPREAD:
        packed_data = {2'b0, c0[CH_W-1 -: W_SIX], 2'b0, c1[CH_W-1 -: W_SIX],
                       2'b0, c2[CH_W-1 -: W_SIX]};
      FMT_888:
        packed_data = {c0, c1, c2};
      default:
        packed_data = '0;
    endcase
  end

endmodule

// File: rtl/pixfmt_sync_path.sv
module pixfmt_sync_path (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic src,
  input  logic inv,
  input  logic neg,
  input  logic dis,
  output logic sync_out
);

  logic rise_d;
  logic rise_q;
  logic fall_q;

  always_comb begin
    if (enable) begin
      rise_d = (src & ~dis) ^ inv;
    end else begin
      rise_d = inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= rise_q;
    end
  end

  assign sync_out = neg ? fall_q : rise_q;

endmodule

// File: rtl/pixfmt_top.sv
module pixfmt_top
  import pixfmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PIX_W-1:0]  pix_rgb,
  input  logic              pix_hsync,
  input  logic              pix_vsync,
  input  logic              pix_de,
  output logic [PIX_W-1:0]  bus_data,
  output logic              bus_hsync,
  output logic              bus_vsync,
  output logic              bus_de,
  output logic              bus_pclk_inv
);

  ctrl_t                ctrl_q;
  logic [PIX_W-1:0]     packed_w;
  logic [PIX_W-1:0]     data_d;
  logic [PIX_W-1:0]     data_q;
  logic                 pclk_d;
  logic                 pclk_q;
  logic                 csync_w;
  logic                 de_src;
  logic [NUM_SYNC-1:0]  sync_src;
  logic [NUM_SYNC-1:0]  sync_out;

  pixfmt_ctrl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl      (ctrl_q)
  );

  pixfmt_pack pack_i (
    .order       (ctrl_q.order),
    .fmt         (ctrl_q.fmt),
    .rgb         (pix_rgb),
    .packed_data (packed_w)
  );

  // Composite sync is low while either sync is active.
  assign csync_w  = ~(pix_hsync | pix_vsync);
  assign de_src   = ctrl_q.de_mode ? pix_de : csync_w;
  assign sync_src = {pix_hsync, pix_vsync, de_src};

  always_comb begin
    data_d = ctrl_q.enable ? packed_w : '0;
    pclk_d = ctrl_q.enable & ctrl_q.pclk_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pclk_q <= 1'b0;
    end else begin
      data_q <= data_d;
      pclk_q <= pclk_d;
    end
  end

  for (genvar gi = 0; gi < NUM_SYNC; gi++) begin : g_sync
    pixfmt_sync_path sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl_q.enable),
      .src      (sync_src[gi]),
      .inv      (ctrl_q.inv[gi]),
      .neg      (ctrl_q.neg[gi]),
      .dis      (ctrl_q.dis[gi]),
      .sync_out (sync_out[gi])
    );
  end

  assign bus_data     = data_q;
  assign bus_hsync    = sync_out[2];
  assign bus_vsync    = sync_out[1];
  assign bus_de       = sync_out[0];
  assign bus_pclk_inv = pclk_q;

endmodule

// File: rtl/pixfmt_checker.sv
module pixfmt_checker
  import pixfmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input ctrl_t             ctrl_q,
  input logic              pix_de,
  input logic [PIX_W-1:0]  bus_data,
  input logic              bus_hsync,
  input logic              bus_de
);

  logic no_wr;
  assign no_wr = ~(reg_valid & reg_write);

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr != '0) |=> (reg_rdata == ID_VALUE)); // R1

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr == '0) |=> (reg_rdata == {{(REG_W-CTRL_W){1'b0}}, $past(ctrl_q)})); // R1

  AST_FMT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.enable && (ctrl_q.fmt == 3'd0 || ctrl_q.fmt == 3'd7)) |=> (bus_data == '0)); // R5

  AST_UPPER_CLEAR_565: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.enable && ctrl_q.fmt == 3'd1) |=> (bus_data[PIX_W-1:16] == '0)); // R3

  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable) |=> (bus_data == '0)); // R9

  AST_HS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (no_wr && ctrl_q.enable && ctrl_q.dis[2] && !ctrl_q.neg[2]) |=> (bus_hsync == $past(ctrl_q.inv[2]))); // R8

  AST_DE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (no_wr && ctrl_q.enable && ctrl_q.de_mode && !ctrl_q.dis[0] && !ctrl_q.neg[0] && !ctrl_q.inv[0])
      |=> (bus_de == $past(pix_de))); // R11

endmodule

bind pixfmt_top pixfmt_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .ctrl_q    (ctrl_q),
  .pix_de    (pix_de),
  .bus_data  (bus_data),
  .bus_hsync (bus_hsync),
  .bus_de    (bus_de)
);

// File: tb/pixfmt_top_tb_top.sv
module pixfmt_top_tb_top;

  localparam int AW = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_valid;
  logic        reg_write;
  logic [AW-1:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [23:0] pix_rgb;
  logic        pix_hsync, pix_vsync, pix_de;
  logic [23:0] bus_data;
  logic        bus_hsync, bus_vsync, bus_de, bus_pclk_inv;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pixfmt_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_rgb(pix_rgb), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
    .bus_data(bus_data), .bus_hsync(bus_hsync), .bus_vsync(bus_vsync),
    .bus_de(bus_de), .bus_pclk_inv(bus_pclk_inv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int en, input int ord, input int fmt, input int mode,
                                     input int inv, input int neg, input int dis, input int pinv);
    return 32'(en + dis * 2 + neg * 16 + inv * 128 + pinv * 1024 +
               fmt * 2048 + ord * 16384 + mode * 65536);
  endfunction

  function automatic logic [23:0] exp_pack(input logic [23:0] p, input int ord, input int fmt);
    int ch[3];
    int s0[4] = '{0, 2, 1, 2};
    int s1[4] = '{1, 1, 0, 0};
    int s2[4] = '{2, 0, 2, 1};
    int c[3];
    int lsb[3];
    int w[3];
    int res;
    ch[0] = int'(p) / 65536;
    ch[1] = (int'(p) / 256) % 256;
    ch[2] = int'(p) % 256;
    c[0] = ch[s0[ord]]; c[1] = ch[s1[ord]]; c[2] = ch[s2[ord]];
    case (fmt)
      1: begin lsb = '{11, 5, 0}; w = '{5, 6, 5}; end
      2: begin lsb = '{16, 8, 0}; w = '{5, 6, 5}; end
      3: begin lsb = '{17, 8, 1}; w = '{5, 6, 5}; end
      4: begin lsb = '{12, 6, 0}; w = '{6, 6, 6}; end
      5: begin lsb = '{16, 8, 0}; w = '{6, 6, 6}; end
      6: begin lsb = '{16, 8, 0}; w = '{8, 8, 8}; end
      default: return 24'h0;
    endcase
    res = 0;
    for (int k = 0; k < 3; k++) res += (c[k] >> (8 - w[k])) << lsb[k];
    return 24'(res);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    d = reg_rdata;
  endtask

  // Drive at a falling edge, then sample 5 ns after the next rising edge.
  task automatic drive(input logic [23:0] p, input logic hs, input logic vs, input logic de);
    @(negedge clk);
    pix_rgb = p; pix_hsync = hs; pix_vsync = vs; pix_de = de;
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [23:0] pix[4];
    pix = '{24'hFFFFFF, 24'h123456, 24'hA5C33C, 24'h807F01};
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = '0; reg_wdata = '0;
    pix_rgb = '0; pix_hsync = 0; pix_vsync = 0; pix_de = 0;
    #45 rst_n = 1;
    check("R9 reset data", 32'(bus_data), 0);
    check("R9 reset syncs", {29'b0, bus_hsync, bus_vsync, bus_de}, 0);
    check("R9 reset pclk", 32'(bus_pclk_inv), 0);

    rd(0, rv); check("R1 ctrl after reset", rv, 0);
    rd(5, rv); check("R1 id read", rv, 32'h00647069);
    rd(15, rv); check("R1 id read top addr", rv, 32'h00647069);
    wr(0, 32'hFFFF_FFFF);
    rd(0, rv); check("R1 reserved bits clear", rv, 32'h0001_FFFF);
    wr(0, 32'h0000_1234);
    wr(3, 32'h0000_5555);
    rd(0, rv); check("R1 write elsewhere ignored", rv, 32'h0000_1234);

    // Channel order and packing sweep.
    for (int o = 0; o < 4; o++) begin
      for (int f = 0; f < 8; f++) begin
        wr(0, mk(1, o, f, 1, 0, 0, 0, 0));
        for (int k = 0; k < 4; k++) begin
          drive(pix[k], 0, 0, 1);
          if (f == 0 || f == 7) check("R5 zero format", 32'(bus_data), 32'(exp_pack(pix[k], o, f)));
          else if (f <= 3) check("R2 R3 565 packing", 32'(bus_data), 32'(exp_pack(pix[k], o, f)));
          else check("R2 R4 666/888 packing", 32'(bus_data), 32'(exp_pack(pix[k], o, f)));
        end
      end
    end

    // Latency of one edge.
    wr(0, mk(1, 0, 6, 1, 0, 0, 0, 0));
    drive(24'h111111, 0, 0, 0);
    @(negedge clk);
    pix_rgb = 24'h222222; pix_de = 1;
    #5;
    check("R11 no change before edge", {7'b0, bus_de, bus_data}, {8'h00, 24'h111111});
    @(posedge clk); #5;
    check("R11 one edge latency", {7'b0, bus_de, bus_data}, {8'h01, 24'h222222});

    // Polarity sweep.
    for (int iv = 0; iv < 8; iv++) begin
      wr(0, mk(1, 0, 6, 1, iv, 0, 0, 0));
      for (int pt = 0; pt < 8; pt++) begin
        drive(24'h0, pt[2], pt[1], pt[0]);
        check("R6 invert", {29'b0, bus_hsync, bus_vsync, bus_de}, 32'(pt ^ iv));
      end
    end

    // Gating sweep with strobes held active.
    for (int ds = 0; ds < 8; ds++) begin
      wr(0, mk(1, 0, 6, 1, 5, 0, ds, 0));
      drive(24'h0, 1, 1, 1);
      check("R8 gate", {29'b0, bus_hsync, bus_vsync, bus_de}, 32'((~ds & 7) ^ 5));
    end

    // Falling-edge launch: each launch pattern against a rising strobe step.
    for (int ng = 0; ng < 8; ng++) begin
      wr(0, mk(1, 0, 6, 1, 0, ng, 0, 0));
      drive(24'h0, 0, 0, 0);
      drive(24'h0, 0, 0, 0);
      drive(24'hABCDEF, 1, 1, 1);
      check("R7 early sample", {29'b0, bus_hsync, bus_vsync, bus_de}, 32'(~ng & 7));
      check("R7 data on rising edge", 32'(bus_data), 32'h00ABCDEF);
      #10;
      check("R7 late sample", {29'b0, bus_hsync, bus_vsync, bus_de}, 32'h7);
    end

    // Composite sync on the data-enable pin.
    for (int ci = 0; ci < 2; ci++) begin
      wr(0, mk(1, 0, 6, 0, ci, 0, 0, 0));
      for (int pt = 0; pt < 8; pt++) begin
        drive(24'h0, pt[2], pt[1], pt[0]);
        check("R10 composite sync", 32'(bus_de), 32'((((pt[2] | pt[1]) ? 0 : 1)) ^ ci));
      end
    end

    // Clock invert request.
    wr(0, mk(1, 0, 6, 1, 0, 0, 0, 1));
    @(posedge clk); #5;
    check("R12 pclk invert set", 32'(bus_pclk_inv), 1);
    wr(0, mk(1, 0, 6, 1, 0, 0, 0, 0));
    @(posedge clk); #5;
    check("R12 pclk invert clear", 32'(bus_pclk_inv), 0);

    // Quiet while disabled, clean restart on enable.
    wr(0, mk(0, 0, 6, 1, 7, 0, 0, 1));
    drive(24'hFFFFFF, 1, 1, 1);
    check("R9 quiet data", 32'(bus_data), 0);
    check("R9 quiet syncs", {29'b0, bus_hsync, bus_vsync, bus_de}, 32'h7);
    check("R9 quiet pclk", 32'(bus_pclk_inv), 0);
    pix_rgb = 24'h5A5A5A; pix_hsync = 0; pix_vsync = 0; pix_de = 1;
    wr(0, mk(1, 0, 6, 1, 0, 0, 0, 0));
    check("R9 no stale data on enable edge", 32'(bus_data), 0);
    @(posedge clk); #5;
    check("R9 first pixel after enable", 32'(bus_data), 32'h005A5A5A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule